// File: doc/BRIEF.md
# Image Sensor Row Readout Sequencer

This block sits on the host side of a CMOS image sensor and paces its readout. On a one-cycle frame request it raises the sensor's frame-sync input for a fixed number of clock cycles. It then issues one row-advance pulse per line. After each pulse it waits for the sensor's row-valid strobe to rise and fall before it asks for the next row. The frame ends when the sensor flags its last line, or when a programmed row budget is used up, whichever comes first. Both sensor control outputs are launched from falling-edge flops. This keeps them clear of the sensor's rising-edge sampling window.

Pixel samples from the sensor lag its row-valid strobe by a fixed pipeline delay. The block delays the strobe by the same amount, captures the pixel bus at that point, and presents the samples on a registered valid/data output. The sensor cannot be stalled, so the capture port has no ready input and no back-pressure. The consumer must take every beat that `cap_valid_o` marks, in the cycle in which it is marked. A one-cycle done pulse tells the host that the controller has gone back to idle.

Top module: `sensor_readout_ctrl`

## Requirements
- R1: `frame_sync_o` and `row_clk_o` change only on the falling clock edge. Each holds its value through the whole high phase of every clock cycle.
- R2: A `frame_start_i` pulse accepted in idle (driven in cycle c) makes `frame_sync_o` high from the falling edge of cycle c+1. It stays high for exactly START_CYC cycles (default 3, must be at least 3).
- R3: `row_clk_o` pulses high for exactly ROW_CYC cycles (default 1). The first row pulse of a frame rises at the same falling edge at which `frame_sync_o` falls, and the two are never high together.
- R4: A later row pulse is issued only after `pix_valid_i` has been seen high and then low. If `pix_valid_i` is driven low in cycle f, the next `row_clk_o` is high from the falling edge of cycle f+1.
- R5: When `last_line_i` is seen high while a row is being read out, no further row pulse is issued and the controller returns to idle when `pix_valid_i` falls.
- R6: `lines_cfg_i` is latched when a frame is accepted. A nonzero value N ends the frame after N rows, even if the sensor has not flagged its last line. A value of 0 means that only `last_line_i` ends the frame.
- R7: `frame_done_o` is high for exactly one cycle per frame. If the final `pix_valid_i` fall is driven in cycle f, the pulse is in cycle f+1.
- R8: A `frame_start_i` pulse that arrives while a frame is in progress is ignored. It starts no new frame-sync pulse and does not change the row count.
- R9: `cap_valid_o` equals `pix_valid_i` delayed by PIX_LAG+1 cycles (PIX_LAG default 5). When `cap_valid_o` is high, `cap_data_o` holds the value of `pix_data_i` from the previous cycle. That is the sample taken PIX_LAG cycles after the matching `pix_valid_i` cycle.
- R10: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared with the sensor |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | One-cycle frame request |
| lines_cfg_i | input | LINE_W | Row budget per frame, 0 = unlimited |
| frame_sync_o | output | 1 | Frame-sync drive to the sensor, falling-edge launched |
| row_clk_o | output | 1 | Row-advance drive to the sensor, falling-edge launched |
| pix_valid_i | input | 1 | Row-valid strobe from the sensor |
| last_line_i | input | 1 | Last-line flag from the sensor |
| pix_data_i | input | PIX_W | Pixel bus from the sensor |
| cap_valid_o | output | 1 | Captured pixel valid, no back-pressure |
| cap_data_o | output | PIX_W | Captured pixel value |
| frame_done_o | output | 1 | One-cycle pulse on return to idle |

## Verification
The sync pulse is due two cycles after the request is driven. A row pulse is due two cycles after the row-valid fall is driven, and the done pulse one cycle after it. A captured pixel is due six cycles after its valid cycle and carries the bus value of cycle five. A sensor model in the bench drives stimulus at a fixed point after each rising edge. It records the cycle number of every event and checks each result in exactly the cycle it is due, not in a window. Pixel values go into a scoreboard queue tagged with their due cycle, and the monitor pops and compares them as beats appear. The control outputs are sampled just after the rising edge and just before the falling edge to prove they change only at the falling edge.

// File: rtl/srd_pkg.sv
package srd_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE     = 3'd0,
    SQ_SYNC     = 3'd1,
    SQ_ROW      = 3'd2,
    SQ_WAIT_ON  = 3'd3,
    SQ_WAIT_OFF = 3'd4
  } sq_state_t;

endpackage

// File: rtl/srd_seq_fsm.sv
module srd_seq_fsm
  import srd_pkg::*;
#(
  parameter int START_CYC = 3,
  parameter int ROW_CYC   = 1,
  parameter int LINE_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic [LINE_W-1:0] lines_cfg_i,
  input  logic              pix_valid_i,
  input  logic              last_line_i,
  output sq_state_t         state_o,
  output logic              frame_done_o
);

  localparam int PH_MAX = (START_CYC > ROW_CYC) ? START_CYC : ROW_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0] SYNC_LAST = PH_W'(START_CYC - 1);
  localparam logic [PH_W-1:0] ROW_LAST  = PH_W'(ROW_CYC - 1);

  sq_state_t         st_q, st_d;
  logic [PH_W-1:0]   ph_q;
  logic [LINE_W-1:0] rows_q;
  logic [LINE_W-1:0] budget_q;
  logic              last_seen_q;
  logic              done_q;
  logic              row_end;
  logic              frame_end;
  logic              enter_row;
  logic              accept;

  // A row is finished once the sensor's valid strobe drops.
  assign row_end   = (st_q == SQ_WAIT_OFF) && !pix_valid_i;
  assign frame_end = last_seen_q || last_line_i ||
                     ((budget_q != '0) && (rows_q == budget_q));
  assign accept    = (st_q == SQ_IDLE) && frame_start_i;
  assign enter_row = (st_d == SQ_ROW) && (st_q != SQ_ROW);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:     if (frame_start_i)      st_d = SQ_SYNC;
      SQ_SYNC:     if (ph_q == SYNC_LAST)  st_d = SQ_ROW;
      SQ_ROW:      if (ph_q == ROW_LAST)   st_d = SQ_WAIT_ON;
      SQ_WAIT_ON:  if (pix_valid_i)        st_d = SQ_WAIT_OFF;
      SQ_WAIT_OFF: if (!pix_valid_i)       st_d = frame_end ? SQ_IDLE : SQ_ROW;
      default:                             st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q)
        ph_q <= '0;
      else if ((st_q == SQ_SYNC) || (st_q == SQ_ROW))
        ph_q <= ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q   <= '0;
      budget_q <= '0;
    end else if (accept) begin
      rows_q   <= '0;
      budget_q <= lines_cfg_i;
    end else if (enter_row) begin
      rows_q   <= rows_q + 1'b1;
    end
  end

  // Last-line flag is held from the row where it appears until the next row.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      last_seen_q <= 1'b0;
    else if (accept || enter_row)
      last_seen_q <= 1'b0;
    else if (((st_q == SQ_WAIT_ON) || (st_q == SQ_WAIT_OFF)) && last_line_i)
      last_seen_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= row_end && frame_end;
  end

  assign state_o      = st_q;
  assign frame_done_o = done_q;

endmodule

// File: rtl/srd_fall_retime.sv
module srd_fall_retime #(
  parameter int NSIG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] d_i,
  output logic [NSIG-1:0] q_o
);

  for (genvar g = 0; g < NSIG; g++) begin : g_bit
    logic q_r;
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= 1'b0;
      else        q_r <= d_i[g];
    end
    assign q_o[g] = q_r;
  end

endmodule

// File: rtl/srd_pixel_align.sv
module srd_pixel_align #(
  parameter int PIX_W   = 10,
  parameter int PIX_LAG = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             cap_valid_o,
  output logic [PIX_W-1:0] cap_data_o
);

  logic [PIX_LAG-1:0] vd_q;
  logic               cv_q;
  logic [PIX_W-1:0]   cd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vd_q[0] <= 1'b0;
    else        vd_q[0] <= pix_valid_i;
  end

  for (genvar s = 1; s < PIX_LAG; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vd_q[s] <= 1'b0;
      else        vd_q[s] <= vd_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q <= 1'b0;
      cd_q <= '0;
    end else begin
      cv_q <= vd_q[PIX_LAG-1];
      if (vd_q[PIX_LAG-1]) cd_q <= pix_data_i;
    end
  end

  assign cap_valid_o = cv_q;
  assign cap_data_o  = cd_q;

endmodule

// File: rtl/sensor_readout_ctrl.sv
module sensor_readout_ctrl
  import srd_pkg::*;
#(
  parameter int PIX_W     = 10,
  parameter int LINE_W    = 11,
  parameter int START_CYC = 3,
  parameter int ROW_CYC   = 1,
  parameter int PIX_LAG   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic [LINE_W-1:0] lines_cfg_i,
  output logic              frame_sync_o,
  output logic              row_clk_o,
  input  logic              pix_valid_i,
  input  logic              last_line_i,
  input  logic [PIX_W-1:0]  pix_data_i,
  output logic              cap_valid_o,
  output logic [PIX_W-1:0]  cap_data_o,
  output logic              frame_done_o
);

  sq_state_t  seq_state;
  logic [1:0] drv_d;
  logic [1:0] drv_q;

  srd_seq_fsm #(
    .START_CYC (START_CYC),
    .ROW_CYC   (ROW_CYC),
    .LINE_W    (LINE_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_i),
    .lines_cfg_i   (lines_cfg_i),
    .pix_valid_i   (pix_valid_i),
    .last_line_i   (last_line_i),
    .state_o       (seq_state),
    .frame_done_o  (frame_done_o)
  );

  assign drv_d = {seq_state == SQ_ROW, seq_state == SQ_SYNC};

  srd_fall_retime #(.NSIG(2)) u_retime (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (drv_d),
    .q_o   (drv_q)
  );

  assign frame_sync_o = drv_q[0];
  assign row_clk_o    = drv_q[1];

  srd_pixel_align #(
    .PIX_W   (PIX_W),
    .PIX_LAG (PIX_LAG)
  ) u_align (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_valid_i (pix_valid_i),
    .pix_data_i  (pix_data_i),
    .cap_valid_o (cap_valid_o),
    .cap_data_o  (cap_data_o)
  );

endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
  parameter int START_CYC = 3,
  parameter int PIX_LAG   = 5
) (
  input logic clk,
  input logic rst_n,
  input logic frame_sync_o,
  input logic row_clk_o,
  input logic pix_valid_i,
  input logic cap_valid_o,
  input logic frame_done_o
);

  logic [3:0] sync_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             sync_run <= '0;
    else if (!frame_sync_o) sync_run <= '0;
    else if (sync_run != 4'hF) sync_run <= sync_run + 1'b1;
  end

  AST_SYNC_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_sync_o) |-> (int'(sync_run) >= START_CYC)); // R2

  AST_NO_SYNC_ROW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_sync_o && row_clk_o)); // R3

  AST_ROW_AFTER_VALID_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_clk_o) |-> !pix_valid_i); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o); // R7

  AST_CAPTURE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid_o == $past(pix_valid_i, PIX_LAG + 1)); // R9

endmodule

bind sensor_readout_ctrl srd_checker #(
  .START_CYC (START_CYC),
  .PIX_LAG   (PIX_LAG)
) u_srd_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_sync_o (frame_sync_o),
  .row_clk_o    (row_clk_o),
  .pix_valid_i  (pix_valid_i),
  .cap_valid_o  (cap_valid_o),
  .frame_done_o (frame_done_o)
);

// File: tb/sensor_readout_ctrl_tb_top.sv
module sensor_readout_ctrl_tb_top;

  localparam int PW = 10;
  localparam int LW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic [LW-1:0] lines_cfg = '0;
  logic          pix_valid = 1'b0;
  logic          last_line = 1'b0;
  logic [PW-1:0] pix_data = '0;
  logic          fs, rc, cv, fd;
  logic [PW-1:0] cd;

  always #10 clk = ~clk;

  sensor_readout_ctrl dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start),
    .lines_cfg_i   (lines_cfg),
    .frame_sync_o  (fs),
    .row_clk_o     (rc),
    .pix_valid_i   (pix_valid),
    .last_line_i   (last_line),
    .pix_data_i    (pix_data),
    .cap_valid_o   (cv),
    .cap_data_o    (cd),
    .frame_done_o  (fd)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Sensor model configuration and bookkeeping
  int s_lines = 1, s_npix = 1, s_blank = 3;
  int s_row = 0, blank_left = -1, pv_left = 0;
  int pv_start = -100, pv_row = 0, pv_n = 0;
  int pv_fall_cyc = -100, req_cyc = -100;
  int fs_rises = 0, rows_seen = 0, done_cnt = 0;
  int fs_len = 0, rc_len = 0;
  bit fs_prev = 0, rc_prev = 0, fd_prev = 0;
  int q_cyc[$];
  int q_dat[$];

  // R1: control outputs sampled after the rising edge and before the falling edge
  initial begin
    forever begin
      logic [1:0] a, b;
      @(posedge clk);
      #1 a = {fs, rc};
      #8 b = {fs, rc};
      if (rst_n) chk(a == b, "R1 control changed in high phase", int'(b), int'(a));
    end
  end

  // Monitor + sensor model: sample results, then drive the next sensor values
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n) begin
        // R9 scoreboard monitor
        if (cv) begin
          if (q_dat.size() == 0) chk(1'b0, "R9 unexpected capture", int'(cd), -1);
          else begin
            int ec, ed;
            ec = q_cyc.pop_front();
            ed = q_dat.pop_front();
            chk(cyc == ec, "R9 capture cycle", cyc, ec);
            chk(int'(cd) == ed, "R9 capture data", int'(cd), ed);
          end
        end
        // R2 frame sync
        if (fs && !fs_prev) begin
          fs_rises++;
          fs_len = 0;
          chk(cyc == req_cyc + 2, "R2 sync start cycle", cyc, req_cyc + 2);
          s_row = 0;
          last_line = 1'b0;
        end
        if (fs) fs_len++;
        if (!fs && fs_prev) begin
          chk(fs_len == 3, "R2 sync width", fs_len, 3);
          chk(rc == 1'b1, "R3 first row at sync fall", int'(rc), 1);
        end
        // R3 / R4 row pulses
        if (rc && !rc_prev) begin
          if (rows_seen > 0)
            chk(cyc == pv_fall_cyc + 2, "R4 row after valid fall", cyc, pv_fall_cyc + 2);
          rows_seen++;
          rc_len = 0;
          blank_left = s_blank;
          last_line = 1'b0;
        end
        if (rc) rc_len++;
        if (!rc && rc_prev) chk(rc_len == 1, "R3 row pulse width", rc_len, 1);
        // R7 done pulse
        if (fd) begin
          done_cnt++;
          chk(cyc == pv_fall_cyc + 1, "R7 done cycle", cyc, pv_fall_cyc + 1);
          chk(!fd_prev, "R7 done single cycle", int'(fd_prev), 0);
        end
        fs_prev = fs;
        rc_prev = rc;
        fd_prev = fd;

        // Sensor drive
        if (blank_left == 0) begin
          pv_left = s_npix;
          pv_n = s_npix;
          pv_start = cyc;
          pv_row = s_row;
          if (s_row == s_lines - 1) last_line = 1'b1;
          blank_left = -1;
        end else if (blank_left > 0) begin
          blank_left--;
        end
        if (pv_left > 0) begin
          pix_valid = 1'b1;
          pv_left--;
        end else if (pix_valid) begin
          pix_valid = 1'b0;
          pv_fall_cyc = cyc;
          s_row++;
        end
        begin
          int k;
          k = cyc - pv_start - 5;
          if (k >= 0 && k < pv_n) begin
            int v;
            v = (pv_row * 37 + k * 5 + 1) & 10'h3FF;
            pix_data = PW'(v);
            q_cyc.push_back(cyc + 1);
            q_dat.push_back(v);
          end else begin
            pix_data = PW'(10'h2AA ^ (cyc & 10'h3FF));
          end
        end
      end
    end
  end

  task automatic run_frame(input int cfg, input int lines, input int npix, input int blank,
                           input int exp_rows, input bit busy_req, input string tag);
    int waited;
    lines_cfg = LW'(cfg);
    s_lines = lines;
    s_npix = npix;
    s_blank = blank;
    fs_rises = 0;
    rows_seen = 0;
    done_cnt = 0;
    @(posedge clk); #3;
    frame_start = 1'b1;
    req_cyc = cyc;
    @(posedge clk); #3;
    frame_start = 1'b0;
    if (busy_req) begin
      while (rows_seen < 1) begin @(posedge clk); #3; end
      frame_start = 1'b1;  // R8: request while busy
      @(posedge clk); #3;
      frame_start = 1'b0;
    end
    waited = 0;
    while (done_cnt == 0 && waited < 5000) begin @(posedge clk); #3; waited++; end
    repeat (40) @(posedge clk);
    #3;
    chk(rows_seen == exp_rows, tag, rows_seen, exp_rows);
    chk(fs_rises == 1, "R8 one sync per frame", fs_rises, 1);
    chk(done_cnt == 1, "R7 one done per frame", done_cnt, 1);
    chk(q_dat.size() == 0, "R9 all pixels captured", q_dat.size(), 0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #3;
    // R10 reset state
    chk(fs == 1'b0, "R10 reset frame_sync", int'(fs), 0);
    chk(rc == 1'b0, "R10 reset row_clk", int'(rc), 0);
    chk(cv == 1'b0, "R10 reset cap_valid", int'(cv), 0);
    chk(cd == '0, "R10 reset cap_data", int'(cd), 0);
    chk(fd == 1'b0, "R10 reset frame_done", int'(fd), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R5 + R8: unlimited budget, sensor flags the third line, stray request mid-frame
    run_frame(0, 3, 8, 4, 3, 1'b1, "R5 rows until last line");
    // R6: budget of 2 rows on a 5-line sensor
    run_frame(2, 5, 6, 3, 2, 1'b0, "R6 rows limited by budget");
    // R5: last line arrives before a budget of 4, single-pixel rows
    run_frame(4, 2, 1, 3, 2, 1'b0, "R5 last line before budget");
    // R6: budget equal to sensor height
    run_frame(3, 3, 4, 5, 3, 1'b0, "R6 budget equals height");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule